// File: doc/BRIEF.md
# Double-Buffered Pipe Access Controller

This block holds the command register and the buffer-ownership state for one FIFO pipe built from two buffers. At any moment one buffer belongs to the serial interface engine (SIE) and the other to the CPU. The CPU uses a 16-bit register to do three things:

- hand the SIE's buffer over to itself (swap);
- discard whatever the SIE's buffer holds (flush);
- watch a busy flag that mirrors the SIE's access activity.

Each command is honoured only for the pipe direction it belongs to. It also needs the pipe handshake to be in the NAK state and the busy flag to read clear. A command that breaks any of these rules is dropped and leaves a sticky error flag behind. While the default control pipe is selected the register does nothing.

The SIE reports a completed buffer fill with a one-cycle claim strobe. The block then marks the SIE-side buffer as holding data. The buffer storage itself, packet handling and DMA sit outside.

Top module: `pipe_own_ctrl`

## Requirements
- R1: After `rst_n` is low at a clock edge, or `soft_rst` is high at one, `cpu_rdata` reads 0, `sie_buf_idx` is 0, `buf_valid` is 0 and `err_flag` is 0.
- R2: While the control pipe is not selected, bit 13 of `cpu_rdata` (the busy flag) equals the value `sie_busy_in` had one clock earlier.
- R3: A write with bit 15 set is a swap request. It is accepted when `pipe_dir_tx`=0 (receive), `pipe_nak`=1 and the busy flag reads 0. After that edge `sie_buf_idx` has advanced to the other buffer, the buffer now on the SIE side has `buf_valid` 0, and both `swap_pulse` and `cpu_rdata[15]` are 1 for that cycle.
- R4: A write with bit 14 set is a flush request. It is accepted when `pipe_dir_tx`=1 (transmit), `pipe_nak`=1 and the busy flag reads 0. After that edge the SIE-side buffer's `buf_valid` bit is 0, `sie_buf_idx` is unchanged, and both `flush_pulse` and `cpu_rdata[14]` are 1 for that cycle.
- R5: A swap or flush request that is not accepted changes neither `sie_buf_idx` nor `buf_valid`, and it sets `err_flag`.
- R6: Once set, `err_flag` stays set until the next reset of either kind.
- R7: A write in which bits 15 and 14 are both 0 changes no state and does not set `err_flag`. Bits 15 and 14 read back 0 one cycle after the write unless a new accepted command arrives.
- R8: Bits 12 to 0 of `cpu_rdata` always read 0, whatever was written.
- R9: While `ctrl_pipe_sel`=1, `cpu_rdata` reads 0, and writes change no state and set no error.
- R10: `sie_claim` sets `buf_valid` of the SIE-side buffer. If it coincides with an accepted swap, the mark lands on the outgoing buffer. If it coincides with an accepted flush, the flush wins.
- R11: A write with bits 15 and 14 both set runs the command that matches the pipe direction, provided its conditions hold, and flags the other one as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous active-high software reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 16 | Register write data (bit 15 swap, bit 14 flush) |
| cpu_rdata | output | 16 | Register read data (bit 15 swap, bit 14 flush, bit 13 busy) |
| ctrl_pipe_sel | input | 1 | Default control pipe selected; register inert |
| pipe_dir_tx | input | 1 | 1 = transmit (CPU writes buffer), 0 = receive |
| pipe_nak | input | 1 | Pipe handshake state is NAK |
| sie_busy_in | input | 1 | SIE is accessing its buffer |
| sie_claim | input | 1 | SIE has filled its buffer |
| sie_buf_idx | output | 1 | Index of the buffer owned by the SIE |
| buf_valid | output | 2 | Per-buffer data-present flags |
| swap_pulse | output | 1 | One-cycle strobe after an accepted swap |
| flush_pulse | output | 1 | One-cycle strobe after an accepted flush |
| err_flag | output | 1 | Sticky rejected-command flag |

## Verification
Several events can fall on the same clock edge:

- a fill claim from the SIE together with an accepted swap or flush;
- a write that sets both command bits at once.

The random stimulus raises the claim strobe often and writes random 16-bit words, so both collisions occur many times. Directed cases also force each collision once. The bench judges every edge against a model that is written out from the requirements. For a swap, the claim must mark the outgoing buffer and the incoming buffer must be empty. For a flush, the buffer must end up empty. For a double-bit write, exactly one command runs and the error flag rises.

// File: rtl/pown_pkg.sv
// Shared constants and types for the pipe ownership controller.
// Assumes exactly two buffers per pipe; the index width is derived.
package pown_pkg;
    localparam int NUM_BUF = 2;
    localparam int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
    typedef logic [IDX_W-1:0] buf_idx_t;
    typedef logic [NUM_BUF-1:0] buf_mask_t;
endpackage

// File: rtl/pown_cmd_qual.sv
// Command qualifier: decides whether a CPU swap or flush request is
// accepted or rejected. Purely combinational. Assumes busy_flag is the
// registered flag the CPU can read, not the raw SIE input.
module pown_cmd_qual (
    input  logic wr_en,
    input  logic inert,
    input  logic swap_bit,
    input  logic flush_bit,
    input  logic dir_tx,
    input  logic nak,
    input  logic busy_flag,
    output logic swap_ok,
    output logic flush_ok,
    output logic reject
);
    logic live_wr;
    logic swap_req;
    logic flush_req;
    logic safe;

    // Qualify each request against direction, handshake and busy state.
    always_comb begin
        live_wr   = wr_en && !inert;
        swap_req  = live_wr && swap_bit;
        flush_req = live_wr && flush_bit;
        safe      = nak && !busy_flag;
        swap_ok   = swap_req && safe && !dir_tx;
        flush_ok  = flush_req && safe && dir_tx;
        reject    = (swap_req && !swap_ok) || (flush_req && !flush_ok);
    end
endmodule

// File: rtl/pown_buf_track.sv
// Buffer ownership tracker: keeps the index of the SIE-owned buffer and
// a data-present flag per buffer. Assumes swap and flush are never
// accepted in the same cycle (they belong to opposite directions).
module pown_buf_track
    import pown_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      soft_rst,
    input  logic      swap_ok,
    input  logic      flush_ok,
    input  logic      claim,
    output buf_idx_t  sie_idx,
    output buf_mask_t valid
);
    buf_idx_t nxt_idx;

    // Next buffer in rotation order.
    always_comb begin
        if (sie_idx == buf_idx_t'(NUM_BUF - 1)) nxt_idx = '0;
        else                                    nxt_idx = sie_idx + buf_idx_t'(1);
    end

    // Owner index: rotates on an accepted swap.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) sie_idx <= '0;
        else if (swap_ok)       sie_idx <= nxt_idx;
    end

    // One data-present flag per buffer.
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        logic on_sie;
        logic incoming;
        assign on_sie   = (sie_idx == buf_idx_t'(g));
        assign incoming = (nxt_idx == buf_idx_t'(g));

        // Flush beats claim; incoming buffer starts empty on a swap.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)       valid[g] <= 1'b0;
            else if (flush_ok && on_sie)  valid[g] <= 1'b0;
            else if (swap_ok && incoming) valid[g] <= 1'b0;
            else if (claim && on_sie)     valid[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/pown_status.sv
// Status holder: registered busy flag, self-clearing command echoes and
// the sticky error flag. Assumes synchronous resets only.
module pown_status (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic busy_in,
    input  logic swap_ok,
    input  logic flush_ok,
    input  logic reject,
    output logic busy_q,
    output logic swap_q,
    output logic flush_q,
    output logic err_q
);
    // Busy mirror and one-cycle command echoes.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            busy_q  <= 1'b0;
            swap_q  <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            busy_q  <= busy_in;
            swap_q  <= swap_ok;
            flush_q <= flush_ok;
        end
    end

    // Sticky record of any rejected command.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) err_q <= 1'b0;
        else if (reject)        err_q <= 1'b1;
    end
endmodule

// File: rtl/pipe_own_ctrl.sv
// Top: command register and ownership logic for one double-buffered pipe.
// Bit REG_W-1 requests a swap, REG_W-2 a flush, REG_W-3 reads busy;
// lower bits are reserved and read 0. Inert while the control pipe is on.
module pipe_own_ctrl
    import pown_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             ctrl_pipe_sel,
    input  logic             pipe_dir_tx,
    input  logic             pipe_nak,
    input  logic             sie_busy_in,
    input  logic             sie_claim,
    output logic [IDX_W-1:0] sie_buf_idx,
    output logic [NUM_BUF-1:0] buf_valid,
    output logic             swap_pulse,
    output logic             flush_pulse,
    output logic             err_flag
);
    localparam int SWAP_POS  = REG_W - 1;
    localparam int FLUSH_POS = REG_W - 2;
    localparam int BUSY_POS  = REG_W - 3;

    logic swap_ok, flush_ok, reject;
    logic busy_q, swap_q, flush_q;

    pown_cmd_qual u_qual (
        .wr_en     (cpu_wr),
        .inert     (ctrl_pipe_sel),
        .swap_bit  (cpu_wdata[SWAP_POS]),
        .flush_bit (cpu_wdata[FLUSH_POS]),
        .dir_tx    (pipe_dir_tx),
        .nak       (pipe_nak),
        .busy_flag (busy_q),
        .swap_ok   (swap_ok),
        .flush_ok  (flush_ok),
        .reject    (reject)
    );

    pown_buf_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .swap_ok  (swap_ok),
        .flush_ok (flush_ok),
        .claim    (sie_claim),
        .sie_idx  (sie_buf_idx),
        .valid    (buf_valid)
    );

    pown_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .busy_in  (sie_busy_in),
        .swap_ok  (swap_ok),
        .flush_ok (flush_ok),
        .reject   (reject),
        .busy_q   (busy_q),
        .swap_q   (swap_q),
        .flush_q  (flush_q),
        .err_q    (err_flag)
    );

    // Register read view; all zero while the control pipe is selected.
    always_comb begin
        cpu_rdata = '0;
        if (!ctrl_pipe_sel) begin
            cpu_rdata[SWAP_POS]  = swap_q;
            cpu_rdata[FLUSH_POS] = flush_q;
            cpu_rdata[BUSY_POS]  = busy_q;
        end
    end

    assign swap_pulse  = swap_q;
    assign flush_pulse = flush_q;
endmodule

// File: rtl/pipe_own_ctrl_chk.sv
// Checker for pipe_own_ctrl, attached by bind. Observes ports only.
module pipe_own_ctrl_chk
    import pown_pkg::*;
#(
    parameter int REG_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               soft_rst,
    input logic               ctrl_pipe_sel,
    input logic               sie_busy_in,
    input logic [REG_W-1:0]   cpu_rdata,
    input logic [IDX_W-1:0]   sie_buf_idx,
    input logic [NUM_BUF-1:0] buf_valid,
    input logic               swap_pulse,
    input logic               flush_pulse,
    input logic               err_flag
);
    // R2: busy bit mirrors the SIE input one clock later.
    p_busy_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(soft_rst) && !ctrl_pipe_sel)
            |-> cpu_rdata[REG_W-3] == $past(sie_busy_in));

    // R3: a swap moves ownership and the incoming buffer is empty.
    p_swap_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> (sie_buf_idx != $past(sie_buf_idx)) && !buf_valid[sie_buf_idx]);

    // R4: a flush leaves the SIE-side buffer empty and ownership in place.
    p_flush_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> !buf_valid[sie_buf_idx] && $stable(sie_buf_idx));

    // R6: error flag is sticky until a reset.
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !soft_rst) |=> err_flag);

    // R8: reserved bits read zero.
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[REG_W-4:0] == '0);

    // R9: register reads zero while the control pipe is selected.
    p_inert_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_pipe_sel |-> cpu_rdata == '0);

    // R11: never both commands accepted together.
    p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(swap_pulse && flush_pulse));
endmodule

bind pipe_own_ctrl pipe_own_ctrl_chk #(.REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .ctrl_pipe_sel (ctrl_pipe_sel),
    .sie_busy_in   (sie_busy_in),
    .cpu_rdata     (cpu_rdata),
    .sie_buf_idx   (sie_buf_idx),
    .buf_valid     (buf_valid),
    .swap_pulse    (swap_pulse),
    .flush_pulse   (flush_pulse),
    .err_flag      (err_flag)
);

// File: tb/sim_pipe_own_ctrl.sv
module sim_pipe_own_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, soft_rst, cpu_wr, ctrl_pipe_sel, pipe_dir_tx;
    logic        pipe_nak, sie_busy_in, sie_claim;
    logic [15:0] cpu_wdata, cpu_rdata;
    logic [0:0]  sie_buf_idx;
    logic [1:0]  buf_valid;
    logic        swap_pulse, flush_pulse, err_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    logic       m_idx, m_busy, m_swap, m_flush, m_err;
    logic [1:0] m_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_own_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ctrl_pipe_sel(ctrl_pipe_sel), .pipe_dir_tx(pipe_dir_tx),
        .pipe_nak(pipe_nak), .sie_busy_in(sie_busy_in), .sie_claim(sie_claim),
        .sie_buf_idx(sie_buf_idx), .buf_valid(buf_valid),
        .swap_pulse(swap_pulse), .flush_pulse(flush_pulse), .err_flag(err_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rdata();
        if (ctrl_pipe_sel) return 16'h0;
        return {m_swap, m_flush, m_busy, 13'h0};
    endfunction

    // Advance the model by one edge using the inputs now applied.
    task automatic model_step();
        logic tr, fr, ok, sok, fok;
        logic [1:0] v;
        if (!rst_n || soft_rst) begin
            m_idx = 0; m_busy = 0; m_swap = 0; m_flush = 0; m_err = 0; m_valid = 0;
            return;
        end
        tr  = cpu_wr && !ctrl_pipe_sel && cpu_wdata[15];
        fr  = cpu_wr && !ctrl_pipe_sel && cpu_wdata[14];
        ok  = pipe_nak && !m_busy;
        sok = tr && ok && !pipe_dir_tx;
        fok = fr && ok && pipe_dir_tx;
        v = m_valid;
        if (sie_claim) v[m_idx] = 1'b1;
        if (fok) v[m_idx] = 1'b0;
        if (sok) v[~m_idx] = 1'b0;
        m_valid = v;
        if (sok) m_idx = ~m_idx;
        m_err   = m_err | (tr && !sok) | (fr && !fok);
        m_busy  = sie_busy_in;
        m_swap  = sok;
        m_flush = fok;
    endtask

    // Compare all outputs with the model.
    task automatic compare_all();
        logic [15:0] er;
        er = exp_rdata();
        if (ctrl_pipe_sel) check("R9 rdata", int'(cpu_rdata), int'(er));
        check("R2 busy", int'(cpu_rdata[13]), int'(er[13]));
        check("R3 swap bit", int'(cpu_rdata[15]), int'(er[15]));
        check("R4 flush bit", int'(cpu_rdata[14]), int'(er[14]));
        check("R8 reserved", int'(cpu_rdata[12:0]), 0);
        check("R3 idx", int'(sie_buf_idx), int'(m_idx));
        check("R10 valid", int'(buf_valid), int'(m_valid));
        check("R3 swap_pulse", int'(swap_pulse), int'(m_swap));
        check("R4 flush_pulse", int'(flush_pulse), int'(m_flush));
        check("R5 err", int'(err_flag), int'(m_err));
    endtask

    // Inputs are set just after a falling edge; results sampled at the next.
    task automatic tick();
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        cpu_wr = 0; cpu_wdata = 16'h0; soft_rst = 0; sie_claim = 0;
        sie_busy_in = 0; ctrl_pipe_sel = 0; pipe_nak = 1;
    endtask

    task automatic wr(input logic [15:0] d);
        cpu_wr = 1; cpu_wdata = d;
    endtask

    initial begin
        void'($urandom(32'd7321));
        rst_n = 0; idle_inputs(); pipe_dir_tx = 0;
        @(negedge clk);
        tick(); tick();
        // R1: reset state
        check("R1 rdata", int'(cpu_rdata), 0);
        check("R1 idx", int'(sie_buf_idx), 0);
        check("R1 valid", int'(buf_valid), 0);
        check("R1 err", int'(err_flag), 0);
        rst_n = 1; tick();

        // R10: claim marks SIE-side buffer 0
        sie_claim = 1; tick(); idle_inputs();
        check("R10 claim", int'(buf_valid), 1);

        // R3 + R10: swap with a coinciding claim on buffer 0
        pipe_dir_tx = 0; wr(16'h8000); sie_claim = 1; tick(); idle_inputs();
        check("R3 idx moved", int'(sie_buf_idx), 1);
        check("R10 outgoing kept", int'(buf_valid), 1);
        check("R3 echo", int'(cpu_rdata[15]), 1);
        tick();
        check("R7 echo clears", int'(cpu_rdata[15]), 0);

        // R4 + R10: flush beats coinciding claim on buffer 1
        pipe_dir_tx = 1; sie_claim = 1; tick();
        check("R10 claim b1", int'(buf_valid), 3);
        wr(16'h4000); sie_claim = 1; tick(); idle_inputs();
        check("R4 flushed", int'(buf_valid), 1);
        check("R4 idx kept", int'(sie_buf_idx), 1);

        // R7: zero command bits, reserved set
        wr(16'h1FFF); tick(); idle_inputs();
        check("R7 no err", int'(err_flag), 0);
        check("R8 reserved", int'(cpu_rdata), 0);

        // R9: inert while control pipe selected
        ctrl_pipe_sel = 1; wr(16'hC000); sie_busy_in = 1; tick(); idle_inputs();
        check("R9 no err", int'(err_flag), 0);
        check("R9 no flush", int'(flush_pulse), 0);

        // R5: flush rejected while busy flag is 1
        sie_busy_in = 1; tick(); sie_claim = 1;
        wr(16'h4000); tick(); idle_inputs();
        check("R5 err set", int'(err_flag), 1);
        check("R5 valid kept", int'(buf_valid), 3);

        // R6: sticky, then R1 via soft reset
        tick(); check("R6 sticky", int'(err_flag), 1);
        soft_rst = 1; tick(); idle_inputs();
        check("R1 soft err", int'(err_flag), 0);
        check("R1 soft valid", int'(buf_valid), 0);

        // R11: both bits in receive direction: swap runs, flush errors
        pipe_dir_tx = 0; wr(16'hC000); tick(); idle_inputs();
        check("R11 swap ran", int'(swap_pulse), 1);
        check("R11 err", int'(err_flag), 1);
        soft_rst = 1; tick(); idle_inputs();

        // R5: swap rejected without NAK
        pipe_nak = 0; wr(16'h8000); tick(); idle_inputs();
        check("R5 nak idx", int'(sie_buf_idx), 0);
        check("R5 nak err", int'(err_flag), 1);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            cpu_wr        = ($urandom_range(0, 9) < 4);
            cpu_wdata     = 16'($urandom());
            ctrl_pipe_sel = ($urandom_range(0, 9) == 0);
            pipe_dir_tx   = 1'($urandom_range(0, 1));
            pipe_nak      = ($urandom_range(0, 9) < 8);
            sie_busy_in   = ($urandom_range(0, 9) < 3);
            sie_claim     = ($urandom_range(0, 9) < 3);
            soft_rst      = ($urandom_range(0, 199) == 0);
            tick();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule